// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a real-time clock core that keeps seconds, minutes, hours, day of month, month, a two-digit year and a weekday, every field held as packed BCD. A one-cycle pulse on `tick_i`, produced elsewhere once per second, advances the count while the run bit is set. Clearing the run bit freezes the count, so a host can rewrite the time without it moving during the update. Host access goes through a flat register port: address, write data, write strobe, read strobe and combinational read data.

Six alarm registers (seconds through year; weekday takes no part) are compared on every advancing tick against the time that tick produces. A full match sets a sticky alarm flag. The flag is cleared by writing a one to it. The interrupt output is the flag gated by an enable bit. The flag is not read directly. A status register returns a snapshot, and that snapshot refreshes only when the status register is read. A host therefore reads it once to refresh it and a second time to see the current state.

Top module: `rtc_core`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, month 01, year 00, weekday 00. Every alarm register, the run bit, the alarm enable and the status snapshot read 0, and `irq_o` is low.
- R2: Register map. Time fields are at 0x00..0x06 in the order seconds, minutes, hours, day, month, year, weekday. Alarm fields are at 0x08..0x0D in the order seconds, minutes, hours, day, month, year. The control register is at 0x10, with bit 0 as the run bit. The alarm enable register is at 0x11, bit 3. Status is at 0x12, with bit 6 as the alarm flag. Unimplemented bits read 0 and time and alarm registers read back as written.
- R3: With run = 1, each tick advances seconds by one BCD step. The new value is readable after the clock edge that samples the tick. With run = 0 a tick changes nothing. A tick in the same cycle as a write to any time register is dropped and the written value stands.
- R4: Seconds and minutes wrap 59 to 00 and carry into the next field. Hours use 24-hour form and wrap 23 to 00, carrying into the day.
- R5: Weekday counts 00..06, steps on every day carry, and wraps 06 to 00.
- R6: The day wraps to 01 after the last day of the month. April, June, September and November have 30 days and February has 28, or 29 when the binary value of the year is divisible by 4. Every other month value, including invalid codes, allows 31 days.
- R7: Month wraps 12 to 01 and carries into the year. The year wraps 99 to 00.
- R8: Non-BCD values are stored as written. On a step, a field at or above its maximum wraps to its minimum and carries. Otherwise a low nibble of 9 or more clears to 0 and increments the high nibble.
- R9: On an advancing tick whose new time equals all six alarm fields, the alarm flag is set at that same clock edge.
- R10: `irq_o` is high exactly when the alarm flag is set and the enable bit is 1.
- R11: Writing status with bit 6 = 1 clears the flag, and writing 0 leaves it alone. An alarm hit in the same cycle as a clearing write leaves the flag set.
- R12: A read of status returns the snapshot taken at the previous status read, and the read itself refreshes the snapshot from the current flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse that advances the time by one second |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, acts at the clock edge |
| rd_en_i | input | 1 | Read strobe, refreshes the status snapshot when addressing status |
| rdata_o | output | 8 | Read data, combinational from the address |
| irq_o | output | 1 | Alarm interrupt |

## Verification
Every register write, time step, flag change and snapshot refresh lands on the single clock edge that samples the strobe or tick. `irq_o` follows the flag in the same cycle, and `rdata_o` follows the address with no clock at all. The bench drives each stimulus on a falling edge and reads the result on the next falling edge, so each check sits one edge after its cause. Snapshot checks use back-to-back reads, where the first read returns the value from before the edge and the second returns the refreshed value. Time sweeps compare every field against an arithmetic calendar model after each tick, covering every month of several leap and non-leap years.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W   = 5;
    localparam int NT       = 7;          // time fields
    localparam int NA       = 6;          // alarm fields
    localparam int TIME_BASE = 0;
    localparam int ALM_BASE  = 8;
    localparam int CTRL_ADDR = 16;
    localparam int IEN_ADDR  = 17;
    localparam int STAT_ADDR = 18;
    localparam int RUN_BIT   = 0;
    localparam int AIE_BIT   = 3;
    localparam int AF_BIT    = 6;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;
    localparam int F_YEAR = 5;
    localparam int F_WDAY = 6;

    typedef logic [NT-1:0][7:0] tvec_t;
    typedef logic [NA-1:0][7:0] avec_t;

    typedef struct packed {
        logic       wrap;
        logic [7:0] val;
    } step_t;

    localparam tvec_t TIME_POR = {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    // One BCD step with wrap when at or beyond the upper bound
    function automatic step_t bcd_step(input logic [7:0] v,
                                       input logic [7:0] lo,
                                       input logic [7:0] hi);
        step_t r;
        if (v >= hi) begin
            r.wrap = 1'b1;
            r.val  = lo;
        end else if (v[3:0] >= 4'd9) begin
            r.wrap = 1'b0;
            r.val  = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r.wrap = 1'b0;
            r.val  = v + 8'd1;
        end
        return r;
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] mon,
                                            input logic [7:0] year);
        logic [7:0] ybin;
        ybin = 8'(year[7:4]) * 8'd10 + 8'(year[3:0]);
        case (mon)
            8'h02:                      last_day = (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
    import rtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          adv_i,
    input  logic [NT-1:0] we_i,
    input  logic [7:0]    wdata_i,
    output tvec_t         cur_o,
    output tvec_t         nxt_o
);

    tvec_t t_q;
    tvec_t t_n;
    step_t s_sec, s_min, s_hr, s_day, s_wd, s_mon, s_yr;

    always_comb begin
        s_sec = bcd_step(t_q[F_SEC],  8'h00, 8'h59);
        s_min = bcd_step(t_q[F_MIN],  8'h00, 8'h59);
        s_hr  = bcd_step(t_q[F_HOUR], 8'h00, 8'h23);
        s_day = bcd_step(t_q[F_DAY],  8'h01, last_day(t_q[F_MON], t_q[F_YEAR]));
        s_wd  = bcd_step(t_q[F_WDAY], 8'h00, 8'h06);
        s_mon = bcd_step(t_q[F_MON],  8'h01, 8'h12);
        s_yr  = bcd_step(t_q[F_YEAR], 8'h00, 8'h99);

        t_n        = t_q;
        t_n[F_SEC] = s_sec.val;
        if (s_sec.wrap) begin
            t_n[F_MIN] = s_min.val;
            if (s_min.wrap) begin
                t_n[F_HOUR] = s_hr.val;
                if (s_hr.wrap) begin
                    t_n[F_DAY]  = s_day.val;
                    t_n[F_WDAY] = s_wd.val;
                    if (s_day.wrap) begin
                        t_n[F_MON] = s_mon.val;
                        if (s_mon.wrap) begin
                            t_n[F_YEAR] = s_yr.val;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= TIME_POR;
        end else if (|we_i) begin
            for (int i = 0; i < NT; i++) begin
                if (we_i[i]) t_q[i] <= wdata_i;
            end
        end else if (adv_i) begin
            t_q <= t_n;
        end
    end

    assign cur_o = t_q;
    assign nxt_o = t_n;

    // R3
    frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && (we_i == '0)) |=> $stable(t_q));

    // R4
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && (we_i == '0) && t_q[F_SEC] == 8'h59) |=> (t_q[F_SEC] == 8'h00));

    // R7
    year_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && (we_i == '0) && t_q[F_YEAR] == 8'h99 && t_q[F_MON] == 8'h12 &&
         t_q[F_DAY] == 8'h31 && t_q[F_HOUR] == 8'h23 && t_q[F_MIN] == 8'h59 &&
         t_q[F_SEC] == 8'h59) |=> (t_q[F_YEAR] == 8'h00 && t_q[F_MON] == 8'h01));

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          adv_i,
    input  tvec_t         nxt_i,
    input  logic [NA-1:0] we_i,
    input  logic [7:0]    wdata_i,
    input  logic          clr_i,
    input  logic          stat_rd_i,
    output avec_t         alm_o,
    output logic          flag_o,
    output logic          snap_o
);

    avec_t         alm_q;
    logic [NA-1:0] fld_eq;
    logic          hit;
    logic          flag_q;
    logic          snap_q;

    for (genvar i = 0; i < NA; i++) begin : g_cmp
        assign fld_eq[i] = (alm_q[i] == nxt_i[i]);
    end

    assign hit = adv_i && (&fld_eq);

    always_ff @(posedge clk) begin
        if (rst) begin
            alm_q <= '0;
        end else begin
            for (int i = 0; i < NA; i++) begin
                if (we_i[i]) alm_q[i] <= wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= 1'b0;
        end else if (stat_rd_i) begin
            snap_q <= flag_q;
        end
    end

    assign alm_o  = alm_q;
    assign flag_o = flag_q;
    assign snap_o = snap_q;

    // R9
    flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(hit));

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_i) |=> flag_q);

    // R11
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !hit) |=> !flag_q);

    // R12
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_rd_i |=> $stable(snap_q));

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [7:0]        rdata_o,
    output logic              irq_o
);

    logic [NT-1:0] t_we;
    logic [NA-1:0] a_we;
    logic          run_q;
    logic          aie_q;
    logic          adv;
    logic          clr;
    logic          stat_rd;
    logic          flag;
    logic          snap;
    tvec_t         cur_t;
    tvec_t         nxt_t;
    avec_t         alm;

    for (genvar i = 0; i < NT; i++) begin : g_twe
        assign t_we[i] = wr_en_i && (addr_i == ADDR_W'(TIME_BASE + i));
    end

    for (genvar i = 0; i < NA; i++) begin : g_awe
        assign a_we[i] = wr_en_i && (addr_i == ADDR_W'(ALM_BASE + i));
    end

    assign adv     = tick_i && run_q && (t_we == '0);
    assign clr     = wr_en_i && (addr_i == ADDR_W'(STAT_ADDR)) && wdata_i[AF_BIT];
    assign stat_rd = rd_en_i && (addr_i == ADDR_W'(STAT_ADDR));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            aie_q <= 1'b0;
        end else if (wr_en_i) begin
            if (addr_i == ADDR_W'(CTRL_ADDR)) run_q <= wdata_i[RUN_BIT];
            if (addr_i == ADDR_W'(IEN_ADDR))  aie_q <= wdata_i[AIE_BIT];
        end
    end

    rtc_time_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (adv),
        .we_i    (t_we),
        .wdata_i (wdata_i),
        .cur_o   (cur_t),
        .nxt_o   (nxt_t)
    );

    rtc_alarm_unit u_alm (
        .clk       (clk),
        .rst       (rst),
        .adv_i     (adv),
        .nxt_i     (nxt_t),
        .we_i      (a_we),
        .wdata_i   (wdata_i),
        .clr_i     (clr),
        .stat_rd_i (stat_rd),
        .alm_o     (alm),
        .flag_o    (flag),
        .snap_o    (snap)
    );

    always_comb begin
        rdata_o = 8'h00;
        for (int i = 0; i < NT; i++) begin
            if (addr_i == ADDR_W'(TIME_BASE + i)) rdata_o = cur_t[i];
        end
        for (int i = 0; i < NA; i++) begin
            if (addr_i == ADDR_W'(ALM_BASE + i)) rdata_o = alm[i];
        end
        if (addr_i == ADDR_W'(CTRL_ADDR)) rdata_o[RUN_BIT] = run_q;
        if (addr_i == ADDR_W'(IEN_ADDR))  rdata_o[AIE_BIT] = aie_q;
        if (addr_i == ADDR_W'(STAT_ADDR)) rdata_o[AF_BIT]  = snap;
    end

    assign irq_o = flag && aie_q;

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == ADDR_W'(IEN_ADDR) && !wdata_i[AIE_BIT]) |=> !irq_o);

    // R3
    run_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !wr_en_i) |=> $stable(cur_t));

endmodule

// File: tb/rtc_core_tb_top.sv
module rtc_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic [4:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic       wr_en_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [7:0] rdata_o;
    logic       irq_o;

    int vectors = 0;
    int fails = 0;

    int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_wd;

    always #10 clk = ~clk;

    rtc_core dut_i (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    function automatic logic [7:0] bcd(input int x);
        return 8'((x / 10) * 16 + (x % 10));
    endfunction

    function automatic int dim(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        addr_i = a; rd_en_i = 1'b1;
        #1;
        d = rdata_o;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic tick1;
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic set_time(input int s, input int mi, input int h, input int d,
                            input int mo, input int y, input int w);
        wr(5'h00, bcd(s));  wr(5'h01, bcd(mi)); wr(5'h02, bcd(h));
        wr(5'h03, bcd(d));  wr(5'h04, bcd(mo)); wr(5'h05, bcd(y));
        wr(5'h06, bcd(w));
        m_sec = s; m_min = mi; m_hr = h; m_day = d; m_mon = mo; m_yr = y; m_wd = w;
    endtask

    task automatic model_step;
        m_sec++;
        if (m_sec > 59) begin
            m_sec = 0; m_min++;
            if (m_min > 59) begin
                m_min = 0; m_hr++;
                if (m_hr > 23) begin
                    m_hr = 0; m_wd = (m_wd + 1) % 7; m_day++;
                    if (m_day > dim(m_mon, m_yr)) begin
                        m_day = 1; m_mon++;
                        if (m_mon > 12) begin
                            m_mon = 1; m_yr = (m_yr + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic cmp_time(input string req);
        logic [7:0] d;
        peek(5'h00, d); chk(req, d, bcd(m_sec));
        peek(5'h01, d); chk(req, d, bcd(m_min));
        peek(5'h02, d); chk(req, d, bcd(m_hr));
        peek(5'h03, d); chk(req, d, bcd(m_day));
        peek(5'h04, d); chk(req, d, bcd(m_mon));
        peek(5'h05, d); chk(req, d, bcd(m_yr));
        peek(5'h06, d); chk(req, d, bcd(m_wd));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int yrs[6];
        yrs = '{0, 1, 3, 4, 96, 99};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0; m_wd = 0;
        cmp_time("R1");
        for (int i = 8; i < 14; i++) begin
            peek(5'(i), d); chk("R1", d, 8'h00);
        end
        peek(5'h10, d); chk("R1", d, 8'h00);
        peek(5'h11, d); chk("R1", d, 8'h00);
        peek(5'h12, d); chk("R1", d, 8'h00);
        chk("R1", {7'd0, irq_o}, 8'h00);

        // R2 register map and readback
        for (int i = 0; i < 7; i++) wr(5'(i), 8'(8'h11 * (i + 1)));
        for (int i = 0; i < 7; i++) begin
            peek(5'(i), d); chk("R2", d, 8'(8'h11 * (i + 1)));
        end
        for (int i = 0; i < 6; i++) wr(5'(8 + i), 8'(8'h21 + i));
        for (int i = 0; i < 6; i++) begin
            peek(5'(8 + i), d); chk("R2", d, 8'(8'h21 + i));
        end
        wr(5'h11, 8'hFF); peek(5'h11, d); chk("R2", d, 8'h08);
        wr(5'h11, 8'h00);
        peek(5'h07, d); chk("R2", d, 8'h00);

        // R3 frozen: ticks change nothing
        set_time(10, 20, 5, 15, 6, 21, 3);
        repeat (5) tick1;
        cmp_time("R3");

        // R3 running single step, and tick dropped on a time write
        wr(5'h10, 8'hFF); peek(5'h10, d); chk("R2", d, 8'h01);
        tick1; model_step; cmp_time("R3");
        @(negedge clk);
        addr_i = 5'h00; wdata_i = 8'h30; wr_en_i = 1'b1; tick_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; tick_i = 1'b0;
        m_sec = 30; cmp_time("R3");

        // R4 long sweep across minute and hour rollovers
        set_time(0, 0, 0, 1, 1, 0, 0);
        for (int k = 0; k < 3700; k++) begin
            tick1; model_step; cmp_time("R4");
        end
        set_time(58, 59, 23, 10, 3, 7, 2);
        repeat (3) begin tick1; model_step; cmp_time("R4"); end

        // R5 R6 R7 month ends across leap and non-leap years
        foreach (yrs[j]) begin
            for (int mo = 1; mo <= 12; mo++) begin
                for (int off = 1; off >= 0; off--) begin
                    set_time(59, 59, 23, dim(mo, yrs[j]) - off, mo, yrs[j], mo % 7);
                    tick1; model_step; cmp_time(off == 0 ? "R6" : "R5");
                    tick1; model_step; cmp_time(mo == 12 ? "R7" : "R6");
                end
            end
        end

        // R8 non-BCD values
        set_time(0, 0, 0, 1, 1, 0, 0);
        wr(5'h00, 8'h5A);
        tick1;
        peek(5'h00, d); chk("R8", d, 8'h00);
        peek(5'h01, d); chk("R8", d, 8'h01);
        wr(5'h00, 8'h0F);
        tick1;
        peek(5'h00, d); chk("R8", d, 8'h10);
        wr(5'h00, 8'h59); wr(5'h01, 8'h59); wr(5'h02, 8'h25); wr(5'h03, 8'h05);
        tick1;
        peek(5'h02, d); chk("R8", d, 8'h00);
        peek(5'h03, d); chk("R8", d, 8'h06);
        wr(5'h00, 8'h59); wr(5'h01, 8'h59); wr(5'h02, 8'h23);
        wr(5'h03, 8'h31); wr(5'h04, 8'h15); wr(5'h05, 8'h20);
        tick1;
        peek(5'h03, d); chk("R8", d, 8'h01);
        peek(5'h04, d); chk("R8", d, 8'h01);
        peek(5'h05, d); chk("R8", d, 8'h21);

        // R9 R10 R12 alarm hit exactly on the matching tick
        set_time(0, 0, 10, 9, 9, 9, 1);
        wr(5'h08, 8'h03); wr(5'h09, 8'h00); wr(5'h0A, 8'h10);
        wr(5'h0B, 8'h09); wr(5'h0C, 8'h09); wr(5'h0D, 8'h09);
        wr(5'h11, 8'h08);
        rd(5'h12, d); rd(5'h12, d); chk("R12", d, 8'h00);
        tick1; tick1;
        chk("R9", {7'd0, irq_o}, 8'h00);
        tick1;
        chk("R9", {7'd0, irq_o}, 8'h01);
        rd(5'h12, d); chk("R12", d, 8'h00);
        rd(5'h12, d); chk("R12", d, 8'h40);

        // R11 write 0 keeps flag, write 1 clears it
        wr(5'h12, 8'h00); chk("R11", {7'd0, irq_o}, 8'h01);
        wr(5'h12, 8'h40); chk("R11", {7'd0, irq_o}, 8'h00);
        rd(5'h12, d); chk("R12", d, 8'h40);
        rd(5'h12, d); chk("R12", d, 8'h00);

        // R10 enable off: flag set, irq low
        wr(5'h11, 8'h00);
        set_time(2, 0, 10, 9, 9, 9, 1);
        tick1;
        chk("R10", {7'd0, irq_o}, 8'h00);
        rd(5'h12, d); rd(5'h12, d); chk("R10", d, 8'h40);
        wr(5'h11, 8'h08);
        chk("R10", {7'd0, irq_o}, 8'h01);

        // R11 hit in the same cycle as a clearing write keeps the flag
        set_time(2, 0, 10, 9, 9, 9, 1);
        @(negedge clk);
        addr_i = 5'h12; wdata_i = 8'h40; wr_en_i = 1'b1; tick_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; tick_i = 1'b0;
        chk("R11", {7'd0, irq_o}, 8'h01);
        wr(5'h12, 8'h40);
        chk("R11", {7'd0, irq_o}, 8'h00);

        // R9 frozen clock cannot raise the alarm
        wr(5'h10, 8'h00);
        set_time(2, 0, 10, 9, 9, 9, 1);
        tick1;
        chk("R9", {7'd0, irq_o}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule